// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block is a slave port that gives an external host read and write access to the processor's internal program memory and data memory. The host uses one shared 16-bit bus for both addresses and data. It first latches an address with an address strobe. It then runs data cycles, each qualified by the port select together with a read strobe or a write strobe. An acknowledge output tells the host when the port is ready for the next cycle. The host drops its strobes only after the acknowledge has returned high.

Data-memory words are 16 bits wide and take one bus cycle each. Program-memory words are 24 bits wide and take two bus cycles to the same word. The latched address advances by itself after each complete word, so the host can stream consecutive words without latching a new address.

When the host is chosen as the boot source, the block holds the processor core in reset until the host has written program word 0. The internal memory side is a simple single-port request interface. Read data comes back one clock after the request.

Top module: `host_mem_port`

## Requirements
- R1: When `h_ale_i` is high while the port is idle, bit 15 of `h_din_i` is latched as the space select (1 = program memory, 0 = data memory) and bits 14:0 are latched as the word address, which appears on `mem_addr_o` and `mem_pm_o` at the next access.
- R2: A data-memory write cycle issues one memory write that carries the 16 bus bits in `mem_wdata_o[15:0]` with the upper 8 bits zero.
- R3: `h_ack_o` is high after reset. It goes low on the clock after a cycle start is sampled (select high with a read or write strobe while idle), stays low for exactly two clocks, and then stays high until the strobes are released and a new cycle starts.
- R4: A program word is written in two cycles. The first cycle carries word bits 23:8. The second carries bits 7:0 in its low byte and issues the single memory write of the full 24-bit word.
- R5: `h_dout_o` keeps the previous read result while a read cycle is in progress. It takes the new value on the same clock on which `h_ack_o` rises.
- R6: A program word is read in two cycles with one memory read. The first cycle returns bits 23:8. The second returns bits 7:0 in the low byte with the upper byte zero.
- R7: The word address increments by one after each complete word: after every data-memory cycle, and after the second cycle of a program word but not after the first.
- R8: Latching an address restarts the two-cycle sequence at the first half.
- R9: With `boot_host_i` high, `core_hold_o` is high from reset until a program-memory write to word 0 completes. Writes to data memory or to other program words do not release it. With `boot_host_i` low, `core_hold_o` is low.
- R10: Each memory access raises `mem_req_o` for exactly one clock, and `h_ack_o` is low during that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_host_i | input | 1 | Host selected as boot source |
| h_sel_i | input | 1 | Port select from host |
| h_rd_i | input | 1 | Host read strobe |
| h_wr_i | input | 1 | Host write strobe |
| h_ale_i | input | 1 | Host address latch strobe |
| h_din_i | input | 16 | Bus value driven by host |
| h_dout_o | output | 16 | Read data driven toward host |
| h_doe_o | output | 1 | Bus drive enable during reads |
| h_ack_o | output | 1 | Ready / access complete |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_pm_o | output | 1 | 1 = program memory, 0 = data memory |
| mem_addr_o | output | 15 | Memory word address |
| mem_wdata_o | output | 24 | Memory write data |
| mem_rdata_i | input | 24 | Memory read data, valid one clock after request |
| core_hold_o | output | 1 | Holds the processor core in reset |

## Verification
A half-toggle that has gone wrong shows on the second program-word cycle: the host gets the wrong byte, or a memory write has the halves swapped. This appears within one host cycle, and it also shifts every later address. A stuck address counter repeats or skips words on the very next streamed access. A controller state held too long or too short shows directly as a wrong acknowledge width, and can be seen within three clocks of the cycle start. A wrong boot flag leaves the core held after program word 0 is written, or releases it earlier.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_FIN  = 2'd2,
    ST_HOLD = 2'd3
  } hmp_state_t;
endpackage

// File: rtl/hmp_ctrl.sv
module hmp_ctrl
  import hmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic       is_pm_i,
  input  logic       half_i,
  output hmp_state_t st_o,
  output logic       start_o,
  output logic       fin_o,
  output logic       cyc_rd_o,
  output logic       ack_o,
  output logic       mem_req_o,
  output logic       mem_we_o
);
  hmp_state_t st_q, st_n;
  logic       strobe, rd_now, need_mem;
  logic       cyc_rd_q, cyc_rd_n, ack_q, ack_n;

  assign strobe  = sel_i & (rd_i | wr_i);
  assign rd_now  = rd_i & ~wr_i;
  assign start_o = (st_q == ST_IDLE) & strobe;

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE: if (strobe) st_n = ST_MEM;
      ST_MEM:  st_n = ST_FIN;
      ST_FIN:  st_n = ST_HOLD;
      default: if (!strobe) st_n = ST_IDLE;
    endcase
    cyc_rd_n = start_o ? rd_now : cyc_rd_q;
    ack_n    = !((st_n == ST_MEM) || (st_n == ST_FIN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cyc_rd_q <= 1'b0;
      ack_q    <= 1'b1;
    end else begin
      st_q     <= st_n;
      cyc_rd_q <= cyc_rd_n;
      ack_q    <= ack_n;
    end
  end

  // data memory always; program memory on read first half or write second half
  assign need_mem  = ~is_pm_i | (cyc_rd_q ? ~half_i : half_i);
  assign mem_req_o = (st_q == ST_MEM) & need_mem;
  assign mem_we_o  = ~cyc_rd_q;
  assign fin_o     = (st_q == ST_FIN);
  assign cyc_rd_o  = cyc_rd_q;
  assign ack_o     = ack_q;
  assign st_o      = st_q;
endmodule

// File: rtl/hmp_addr.sv
module hmp_addr #(
  parameter int DW = 16,
  parameter int AW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_i,
  input  logic [DW-1:0] din_i,
  input  logic          fin_i,
  output logic [AW-1:0] addr_o,
  output logic          is_pm_o,
  output logic          half_o,
  output logic          word_done_o
);
  logic [AW-1:0] addr_q, addr_n;
  logic          pm_q, pm_n, half_q, half_n;

  assign word_done_o = fin_i & (~pm_q | half_q);

  always_comb begin
    addr_n = addr_q;
    pm_n   = pm_q;
    half_n = half_q;
    if (latch_i) begin
      addr_n = din_i[AW-1:0];
      pm_n   = din_i[DW-1];
      half_n = 1'b0;
    end else if (fin_i) begin
      if (pm_q)        half_n = ~half_q;
      if (word_done_o) addr_n = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pm_q   <= 1'b0;
      half_q <= 1'b0;
    end else begin
      addr_q <= addr_n;
      pm_q   <= pm_n;
      half_q <= half_n;
    end
  end

  assign addr_o  = addr_q;
  assign is_pm_o = pm_q;
  assign half_o  = half_q;
endmodule

// File: rtl/hmp_data.sv
module hmp_data #(
  parameter int DW = 16,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          hi_cap_i,
  input  logic          fin_i,
  input  logic          cyc_rd_i,
  input  logic          is_pm_i,
  input  logic          half_i,
  input  logic [DW-1:0] din_i,
  input  logic [PW-1:0] mem_rdata_i,
  output logic [DW-1:0] dout_o,
  output logic [PW-1:0] mem_wdata_o
);
  localparam int LW = PW - DW;

  logic [DW-1:0] wbuf_q, wbuf_n, hi_q, hi_n, dout_q, dout_n;
  logic [LW-1:0] lo_q, lo_n;

  always_comb begin
    wbuf_n = start_i  ? din_i : wbuf_q;
    hi_n   = hi_cap_i ? din_i : hi_q;
    dout_n = dout_q;
    lo_n   = lo_q;
    if (fin_i && cyc_rd_i) begin
      if (!is_pm_i) begin
        dout_n = mem_rdata_i[DW-1:0];
      end else if (!half_i) begin
        dout_n = mem_rdata_i[PW-1:LW];
        lo_n   = mem_rdata_i[LW-1:0];
      end else begin
        dout_n = {{(DW-LW){1'b0}}, lo_q};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf_q <= '0;
      hi_q   <= '0;
      dout_q <= '0;
      lo_q   <= '0;
    end else begin
      wbuf_q <= wbuf_n;
      hi_q   <= hi_n;
      dout_q <= dout_n;
      lo_q   <= lo_n;
    end
  end

  assign mem_wdata_o = is_pm_i ? {hi_q, wbuf_q[LW-1:0]} : {{LW{1'b0}}, wbuf_q};
  assign dout_o      = dout_q;
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hmp_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 24,
  parameter int AW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_host_i,
  input  logic          h_sel_i,
  input  logic          h_rd_i,
  input  logic          h_wr_i,
  input  logic          h_ale_i,
  input  logic [DW-1:0] h_din_i,
  output logic [DW-1:0] h_dout_o,
  output logic          h_doe_o,
  output logic          h_ack_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_pm_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [PW-1:0] mem_wdata_o,
  input  logic [PW-1:0] mem_rdata_i,
  output logic          core_hold_o
);
  logic [1:0]    rst_q;
  logic          rst_s;
  hmp_state_t    st;
  logic          start, fin, cyc_rd, is_pm, half, word_done, latch, hi_cap;
  logic [AW-1:0] addr;
  logic          booted_q, booted_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  hmp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s), .sel_i(h_sel_i), .rd_i(h_rd_i), .wr_i(h_wr_i),
    .is_pm_i(is_pm), .half_i(half), .st_o(st), .start_o(start), .fin_o(fin),
    .cyc_rd_o(cyc_rd), .ack_o(h_ack_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o)
  );

  assign latch = h_ale_i & (st == ST_IDLE) & ~start;

  hmp_addr #(.DW(DW), .AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_s), .latch_i(latch), .din_i(h_din_i), .fin_i(fin),
    .addr_o(addr), .is_pm_o(is_pm), .half_o(half), .word_done_o(word_done)
  );

  assign hi_cap = start & ~(h_rd_i & ~h_wr_i) & is_pm & ~half;

  hmp_data #(.DW(DW), .PW(PW)) u_data (
    .clk(clk), .rst_n(rst_s), .start_i(start), .hi_cap_i(hi_cap), .fin_i(fin),
    .cyc_rd_i(cyc_rd), .is_pm_i(is_pm), .half_i(half), .din_i(h_din_i),
    .mem_rdata_i(mem_rdata_i), .dout_o(h_dout_o), .mem_wdata_o(mem_wdata_o)
  );

  always_comb begin
    booted_n = booted_q | (word_done & ~cyc_rd & is_pm & (addr == '0));
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) booted_q <= 1'b0;
    else        booted_q <= booted_n;
  end

  assign core_hold_o = boot_host_i & ~booted_q;
  assign h_doe_o     = h_sel_i & h_rd_i;
  assign mem_pm_o    = is_pm;
  assign mem_addr_o  = addr;
endmodule

// File: rtl/host_mem_port_chk.sv
module host_mem_port_chk
  import hmp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = DW - 1
) (
  input logic          clk,
  input logic          rst_n,
  input hmp_state_t    st,
  input logic          sel,
  input logic          rd,
  input logic          wr,
  input logic          ack,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_pm,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] dout,
  input logic          boot,
  input logic          core_hold
);
  AST_ACK_FALLS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && sel && (rd || wr)) |=> !ack);  // R3
  AST_ACK_TWO_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && $past(!ack)) |=> ack);  // R3
  AST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);  // R10
  AST_REQ_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ack);  // R10
  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_FIN) |=> $stable(dout));  // R5
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_hold) && boot) |-> $past(mem_req && mem_we && mem_pm && mem_addr == '0, 2));  // R9
  AST_NO_HOLD_WITHOUT_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !boot |-> !core_hold);  // R9
endmodule

bind host_mem_port host_mem_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_s), .st(st), .sel(h_sel_i), .rd(h_rd_i), .wr(h_wr_i),
  .ack(h_ack_o), .mem_req(mem_req_o), .mem_we(mem_we_o), .mem_pm(mem_pm_o),
  .mem_addr(mem_addr_o), .dout(h_dout_o), .boot(boot_host_i), .core_hold(core_hold_o)
);

// File: tb/host_mem_port_test.sv
module host_mem_port_test;
  localparam logic [1:0] OP_LAT = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam int NV = 24;
  // {op, bus value, expected read data}
  localparam logic [33:0] VEC [NV] = '{
    {OP_LAT, 16'h0010, 16'h0000}, {OP_WR, 16'h1234, 16'h0000},
    {OP_WR,  16'hABCD, 16'h0000}, {OP_LAT, 16'h0010, 16'h0000},
    {OP_RD,  16'h0000, 16'h1234}, {OP_RD,  16'h0000, 16'hABCD},
    {OP_LAT, 16'h8005, 16'h0000}, {OP_WR,  16'hA1B2, 16'h0000},
    {OP_WR,  16'h00C3, 16'h0000}, {OP_WR,  16'h0102, 16'h0000},
    {OP_WR,  16'h0304, 16'h0000}, {OP_LAT, 16'h8005, 16'h0000},
    {OP_RD,  16'h0000, 16'hA1B2}, {OP_RD,  16'h0000, 16'h00C3},
    {OP_RD,  16'h0000, 16'h0102}, {OP_RD,  16'h0000, 16'h0004},
    {OP_LAT, 16'h8005, 16'h0000}, {OP_RD,  16'h0000, 16'hA1B2},
    {OP_LAT, 16'h8005, 16'h0000}, {OP_RD,  16'h0000, 16'hA1B2},
    {OP_LAT, 16'h0011, 16'h0000}, {OP_RD,  16'h0000, 16'hABCD},
    {OP_LAT, 16'h0010, 16'h0000}, {OP_RD,  16'h0000, 16'h1234}
  };

  logic clk = 1'b0, rst_n = 1'b0, boot = 1'b1;
  logic sel = 1'b0, rd = 1'b0, wr = 1'b0, ale = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic doe, ack, mreq, mwe, mpm, hold;
  logic [14:0] maddr;
  logic [23:0] mwdata;
  logic [23:0] mrdata = '0;
  logic [23:0] pm [256];
  logic [15:0] dm [256];
  int n_chk = 0, n_err = 0, req_cnt = 0;

  always #10 clk = ~clk;

  host_mem_port uut (
    .clk(clk), .rst_n(rst_n), .boot_host_i(boot), .h_sel_i(sel), .h_rd_i(rd),
    .h_wr_i(wr), .h_ale_i(ale), .h_din_i(din), .h_dout_o(dout), .h_doe_o(doe),
    .h_ack_o(ack), .mem_req_o(mreq), .mem_we_o(mwe), .mem_pm_o(mpm),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .core_hold_o(hold)
  );

  // memory model with one clock read latency
  always @(posedge clk) begin
    if (mreq) begin
      req_cnt <= req_cnt + 1;
      if (mwe) begin
        if (mpm) pm[maddr[7:0]] <= mwdata;
        else     dm[maddr[7:0]] <= mwdata[15:0];
      end else begin
        mrdata <= mpm ? pm[maddr[7:0]] : {8'h00, dm[maddr[7:0]]};
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_latch(input logic [15:0] a);
    @(negedge clk); ale = 1'b1; din = a;
    @(negedge clk); ale = 1'b0;
  endtask

  task automatic do_cycle(input logic is_rd, input logic [15:0] d, output logic [15:0] q);
    @(negedge clk); din = d; sel = 1'b1; rd = is_rd; wr = ~is_rd;
    @(negedge clk);
    while (!ack) @(negedge clk);
    q = dout;
    sel = 1'b0; rd = 1'b0; wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] q;
    int c0;
    for (int i = 0; i < 256; i++) begin pm[i] = '0; dm[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 reset ack", 32'(ack), 32'd1);
    check("R10 reset req", 32'(mreq), 32'd0);
    check("R5 reset dout", 32'(dout), 32'h0);
    check("R9 reset hold", 32'(hold), 32'd1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][33:32])
        OP_LAT: do_latch(VEC[i][31:16]);
        OP_WR:  do_cycle(1'b0, VEC[i][31:16], q);
        default: begin
          do_cycle(1'b1, 16'h0, q);
          check($sformatf("R1/R6/R7/R8 vector %0d", i), 32'(q), 32'(VEC[i][15:0]));
        end
      endcase
    end
    check("R2 dm word", 32'(dm[16]), 32'h1234);
    check("R4 pm word 5", 32'(pm[5]), 32'hA1B2C3);
    check("R7 pm word 6", 32'(pm[6]), 32'h010204);
    check("R9 still held", 32'(hold), 32'd1);

    // R3 and R5: acknowledge width and held read data
    do_latch(16'h0011);
    @(negedge clk); sel = 1'b1; rd = 1'b1;
    @(negedge clk);
    check("R3 ack low 1", 32'(ack), 32'd0);
    check("R5 old data held", 32'(dout), 32'h1234);
    @(negedge clk);
    check("R3 ack low 2", 32'(ack), 32'd0);
    @(negedge clk);
    check("R3 ack high", 32'(ack), 32'd1);
    check("R5 new data", 32'(dout), 32'hABCD);
    repeat (2) @(negedge clk);
    check("R3 ack stays high", 32'(ack), 32'd1);
    sel = 1'b0; rd = 1'b0;
    @(negedge clk);

    // R6 and R10: one memory read per program word
    do_latch(16'h8005);
    c0 = req_cnt;
    do_cycle(1'b1, 16'h0, q);
    do_cycle(1'b1, 16'h0, q);
    check("R6 one req per pm read", req_cnt - c0, 32'd1);
    check("R6 low half", 32'(q), 32'h00C3);

    // R9: boot release only by program word 0
    do_latch(16'h0000);
    do_cycle(1'b0, 16'h5555, q);
    check("R9 dm write keeps hold", 32'(hold), 32'd1);
    do_latch(16'h8000);
    do_cycle(1'b0, 16'hDEAD, q);
    check("R9 first half keeps hold", 32'(hold), 32'd1);
    do_cycle(1'b0, 16'h00BE, q);
    check("R9 released", 32'(hold), 32'd0);
    check("R4 pm word 0", 32'(pm[0]), 32'hDEADBE);
    boot = 1'b0;
    @(negedge clk);
    check("R9 no boot", 32'(hold), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule